// File: doc/BRIEF.md
# Warp Divergence and Reconvergence Controller

This block keeps the control state of a single warp of parallel lanes as it runs through branches. It holds the active-lane mask and the program counter. It also holds a last-in first-out stack of reconvergence tokens, which lets lanes that took different paths join up again later. The issue stage presents one decoded control event per cycle:

- a plain sequential step,
- a predicated non-branch instruction,
- a synchronization marker that records where the paths will join,
- a predicated branch with its target and a per-lane predicate vector.

Any sequential or predicated instruction may also carry a pop flag. The pop flag unwinds one token.

A branch is split only when the active lanes disagree on its predicate. When that happens, the lanes that take the branch run first and the other lanes are saved on the stack. The controller then stalls the issue stage for a fixed number of cycles. A branch that all active lanes resolve the same way changes only the program counter. Such a branch needs no token and works even with an empty stack. Two combinational outputs report the predicate seen through the active mask: a per-lane ballot and an all-active-lanes vote.

Top module: `simt_reconv_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the stack is emptied, `active_mask` becomes all ones, `pc` loads `start_pc`, and `busy`, `overflow` and `underflow` are 0.
- R2: An accepted event with `ev_op` = 2'b00 (sequential) or 2'b11 (predicated non-branch) and `ev_pop` = 0 advances `pc` by one. It leaves `active_mask` and the stack unchanged, whatever `ev_pred` holds.
- R3: An accepted event with `ev_op` = 2'b01 (synchronization marker) pushes a token of kind SYNC holding `ev_addr` and the current `active_mask`, and advances `pc` by one.
- R4: An accepted event with `ev_op` = 2'b10 (branch) whose predicate is 1 on every active lane sets `pc` to `ev_addr`. If the predicate is 0 on every active lane, `pc` advances by one. In both cases the mask and stack are unchanged, and this holds with an empty stack.
- R5: A branch whose predicate differs among active lanes pushes a token of kind DIVERGE holding `pc`+1 and the active lanes with predicate 0. It then sets `active_mask` to the active lanes with predicate 1 and `pc` to `ev_addr`. The active mask is never all zeros.
- R6: An accepted sequential or predicated event with `ev_pop` = 1 on a non-empty stack removes the newest token and loads `active_mask` and `pc` from it (last in, first out).
- R7: After a splitting branch, `busy` is 1 for exactly DIV_CYCLES (default 32) consecutive cycles. No event is accepted while `busy` is 1.
- R8: A push on a stack already holding DEPTH (default 16) tokens sets `overflow` for one cycle and leaves the stack unchanged. A splitting branch in that case also leaves `active_mask` and `pc` unchanged and raises no `busy`.
- R9: A pop on an empty stack sets `underflow` for one cycle and leaves `active_mask` and `pc` unchanged.
- R10: `ballot` equals `ev_pred` AND `active_mask`. `vote_all` is 1 exactly when `ev_pred` is 1 on every active lane. Predicate bits of inactive lanes affect neither output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pc | input | PC_W | Program counter loaded at reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_op | input | 2 | Event kind: 00 sequential, 01 sync marker, 10 branch, 11 predicated non-branch |
| ev_pop | input | 1 | Pop flag on sequential or predicated events |
| ev_addr | input | PC_W | Reconvergence address (marker) or branch target |
| ev_pred | input | LANES | Per-lane predicate |
| active_mask | output | LANES | Lanes currently executing |
| pc | output | PC_W | Program counter for the next fetch |
| busy | output | 1 | Stall after a split branch |
| overflow | output | 1 | One-cycle pulse: push on full stack |
| underflow | output | 1 | One-cycle pulse: pop on empty stack |
| vote_all | output | 1 | Predicate true on all active lanes |
| ballot | output | LANES | Predicate masked by the active lanes |

## Verification
The bench separates uniform branches from splitting ones, including branches whose only disagreeing predicate bits sit on inactive lanes. A design that split on raw predicate bits would push tokens and stall there. It unwinds a nested marker-plus-split sequence so that the not-taken lanes resume before the full mask returns. A stack in the wrong order would restore the reconvergence address first. It fills the stack to its limit and then pushes and pops past both ends. A design that overwrote the top token or wrapped its pointer would return the wrong address on the next pop. It also counts the exact stall length and fires an event into the stall window, which catches off-by-one counters and leaky accept logic.

// File: rtl/simt_reconv_pkg.sv
package simt_reconv_pkg;
  typedef enum logic [1:0] {
    OP_SEQ  = 2'b00,
    OP_SSY  = 2'b01,
    OP_BRA  = 2'b10,
    OP_PRED = 2'b11
  } op_e;

  typedef enum logic {
    TOK_SYNC = 1'b0,
    TOK_DIV  = 1'b1
  } tok_kind_e;
endpackage

// File: rtl/simt_token_stack.sv
module simt_token_stack #(
  parameter int W     = 65,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[count[AW-1:0]] <= wdata;
  end

  assign top = mem[AW'(count - CW'(1))];

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (push_ok) count <= count + CW'(1);
    else if (pop_ok)  count <= count - CW'(1);
  end

  p_full_push_r8: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (count == $past(count)));

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);

  p_depth_bound_r8: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/simt_branch_eval.sv
module simt_branch_eval #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] mask,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] taken,
  output logic [LANES-1:0] not_taken,
  output logic             all_take,
  output logic             none_take,
  output logic             split
);
  assign taken     = pred & mask;
  assign not_taken = ~pred & mask;
  assign all_take  = (taken == mask);
  assign none_take = (taken == '0);
  assign split     = !all_take && !none_take;
endmodule

// File: rtl/simt_stall_timer.sv
module simt_stall_timer #(
  parameter int CYCLES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  p_countdown_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/simt_reconv_ctrl.sv
module simt_reconv_ctrl #(
  parameter int LANES      = 32,
  parameter int PC_W       = 32,
  parameter int DEPTH      = 16,
  parameter int DIV_CYCLES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  start_pc,
  input  logic             ev_valid,
  input  logic [1:0]       ev_op,
  input  logic             ev_pop,
  input  logic [PC_W-1:0]  ev_addr,
  input  logic [LANES-1:0] ev_pred,
  output logic [LANES-1:0] active_mask,
  output logic [PC_W-1:0]  pc,
  output logic             busy,
  output logic             overflow,
  output logic             underflow,
  output logic             vote_all,
  output logic [LANES-1:0] ballot
);
  import simt_reconv_pkg::*;

  localparam int TW = 1 + PC_W + LANES;

  op_e              op;
  logic             accept, is_pop, is_ssy, is_bra, split_req, push;
  logic [LANES-1:0] taken, not_taken;
  logic             all_take, none_take, split;
  logic [TW-1:0]    wdata, top_q;
  logic             st_empty, st_full;
  tok_kind_e        top_kind;
  logic [PC_W-1:0]  top_pc, pc_inc;
  logic [LANES-1:0] top_mask;

  assign op        = op_e'(ev_op);
  assign accept    = ev_valid && !busy;
  assign is_pop    = accept && ev_pop && (op == OP_SEQ || op == OP_PRED);
  assign is_ssy    = accept && (op == OP_SSY);
  assign is_bra    = accept && (op == OP_BRA);
  assign split_req = is_bra && split;
  assign push      = is_ssy || split_req;
  assign pc_inc    = pc + PC_W'(1);

  simt_branch_eval #(.LANES(LANES)) u_eval (
    .mask      (active_mask),
    .pred      (ev_pred),
    .taken     (taken),
    .not_taken (not_taken),
    .all_take  (all_take),
    .none_take (none_take),
    .split     (split)
  );

  assign wdata = is_ssy ? {TOK_SYNC, ev_addr, active_mask}
                        : {TOK_DIV, pc_inc, not_taken};

  simt_token_stack #(.W(TW), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (is_pop),
    .wdata (wdata),
    .top   (top_q),
    .empty (st_empty),
    .full  (st_full)
  );

  assign top_kind = tok_kind_e'(top_q[TW-1]);
  assign top_pc   = top_q[TW-2 -: PC_W];
  assign top_mask = top_q[LANES-1:0];

  simt_stall_timer #(.CYCLES(DIV_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (split_req && !st_full),
    .busy (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_mask <= '1;
      pc          <= start_pc;
      overflow    <= 1'b0;
      underflow   <= 1'b0;
    end else begin
      overflow  <= push && st_full;
      underflow <= is_pop && st_empty;
      if (accept) begin
        case (op)
          OP_SEQ, OP_PRED: begin
            if (ev_pop) begin
              if (!st_empty) begin
                active_mask <= top_mask;
                pc          <= top_pc;
              end
            end else begin
              pc <= pc_inc;
            end
          end
          OP_SSY: pc <= pc_inc;
          OP_BRA: begin
            if (all_take)       pc <= ev_addr;
            else if (none_take) pc <= pc_inc;
            else if (!st_full) begin
              active_mask <= taken;
              pc          <= ev_addr;
            end
          end
          default: pc <= pc;
        endcase
      end
    end
  end

  assign ballot   = taken;
  assign vote_all = all_take;

  p_mask_live_r5: assert property (@(posedge clk) disable iff (rst)
    active_mask != '0);

  p_split_stalls_r7: assert property (@(posedge clk) disable iff (rst)
    (split_req && !st_full) |=> busy);

  p_busy_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(pc) && $stable(active_mask)));

  p_uf_hold_r9: assert property (@(posedge clk) disable iff (rst)
    underflow |-> ($stable(pc) && $stable(active_mask)));

  p_div_disjoint_r6: assert property (@(posedge clk) disable iff (rst)
    (is_pop && !st_empty && top_kind == TOK_DIV) |-> ((top_mask & active_mask) == '0));
endmodule

// File: tb/simt_reconv_ctrl_bench.sv
module simt_reconv_ctrl_bench;
  localparam int LANES = 32;
  localparam int PC_W  = 32;
  localparam int DEPTH = 16;
  localparam int DIVC  = 32;
  localparam logic [31:0] START = 32'h100;

  logic clk = 1'b0;
  logic rst;
  logic ev_valid, ev_pop;
  logic [1:0] ev_op;
  logic [PC_W-1:0] ev_addr;
  logic [LANES-1:0] ev_pred;
  logic [LANES-1:0] active_mask, ballot;
  logic [PC_W-1:0] pc;
  logic busy, overflow, underflow, vote_all;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  simt_reconv_ctrl #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .DIV_CYCLES(DIVC)) u_simt_reconv_ctrl (
    .clk(clk), .rst(rst), .start_pc(START), .ev_valid(ev_valid), .ev_op(ev_op),
    .ev_pop(ev_pop), .ev_addr(ev_addr), .ev_pred(ev_pred), .active_mask(active_mask),
    .pc(pc), .busy(busy), .overflow(overflow), .underflow(underflow),
    .vote_all(vote_all), .ballot(ballot));

  typedef struct packed {
    logic [1:0]  op;
    logic        pop;
    logic [31:0] addr;
    logic [31:0] pred;
    logic [31:0] mask;
    logic [31:0] pc;
    logic        uf;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 32'h0,   32'h0,        32'hFFFFFFFF, 32'h101, 1'b0},
    '{2'b01, 1'b0, 32'h200, 32'h0,        32'hFFFFFFFF, 32'h102, 1'b0},
    '{2'b10, 1'b0, 32'h150, 32'h0000FFFF, 32'h0000FFFF, 32'h150, 1'b0},
    '{2'b00, 1'b0, 32'h0,   32'h0,        32'h0000FFFF, 32'h151, 1'b0},
    '{2'b11, 1'b0, 32'h0,   32'h00000F0F, 32'h0000FFFF, 32'h152, 1'b0},
    '{2'b10, 1'b0, 32'h170, 32'hFFFFFFFF, 32'h0000FFFF, 32'h170, 1'b0},
    '{2'b10, 1'b0, 32'h180, 32'hFFFF0000, 32'h0000FFFF, 32'h171, 1'b0},
    '{2'b00, 1'b1, 32'h0,   32'h0,        32'hFFFF0000, 32'h103, 1'b0},
    '{2'b00, 1'b0, 32'h0,   32'h0,        32'hFFFF0000, 32'h104, 1'b0},
    '{2'b00, 1'b1, 32'h0,   32'h0,        32'hFFFFFFFF, 32'h200, 1'b0},
    '{2'b10, 1'b0, 32'h300, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h300, 1'b0},
    '{2'b00, 1'b1, 32'h0,   32'h0,        32'hFFFFFFFF, 32'h300, 1'b1}
  };

  function automatic string row_req(input int i);
    case (i)
      0, 3, 4, 8: return "R2";
      1:          return "R3";
      2:          return "R5";
      5, 6, 10:   return "R4";
      7, 9:       return "R6";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ev_valid = 1'b0; ev_pop = 1'b0; ev_op = 2'b00; ev_addr = '0; ev_pred = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive one event at a falling edge; return at the next falling edge
  task automatic step(input logic [1:0] op, input logic pop, input logic [31:0] addr, input logic [31:0] pred);
    ev_op = op; ev_pop = pop; ev_addr = addr; ev_pred = pred; ev_valid = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0; ev_pop = 1'b0;
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; ev_valid = 1'b0; ev_pop = 1'b0; ev_op = 2'b00; ev_addr = '0; ev_pred = '0;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check(active_mask == '1, "R1", 64'(active_mask), 64'hFFFFFFFF);
    check(pc == START, "R1", 64'(pc), 64'(START));
    check(!busy && !overflow && !underflow, "R1", {61'b0, busy, overflow, underflow}, 64'h0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].pop, VECS[i].addr, VECS[i].pred);
      check(active_mask == VECS[i].mask, row_req(i), 64'(active_mask), 64'(VECS[i].mask));
      check(pc == VECS[i].pc, row_req(i), 64'(pc), 64'(VECS[i].pc));
      check(underflow == VECS[i].uf, row_req(i), 64'(underflow), 64'(VECS[i].uf));
      drain();
    end

    // R7 stall length and ignored event during stall
    do_reset();
    step(2'b01, 1'b0, 32'h400, 32'h0);
    step(2'b10, 1'b0, 32'h500, 32'h000000F0);
    begin
      int n = 0;
      while (busy) begin
        n++;
        if (n == 1) begin
          ev_op = 2'b00; ev_valid = 1'b1;
        end else begin
          ev_valid = 1'b0;
        end
        @(negedge clk);
        if (n == 1) check(pc == 32'h500 && active_mask == 32'h000000F0, "R7",
                          {pc, active_mask}, {32'h500, 32'h000000F0});
        if (n > 100) break;
      end
      ev_valid = 1'b0;
      check(n == DIVC, "R7", 64'(n), 64'(DIVC));
    end

    // R10 vote and ballot through the split mask 0x000000F0
    ev_pred = 32'h0000000F;
    #1;
    check(ballot == 32'h0 && !vote_all, "R10", {31'b0, vote_all, ballot}, 64'h0);
    ev_pred = 32'hFFFF0F30;
    #1;
    check(ballot == 32'h00000030 && !vote_all, "R10", {31'b0, vote_all, ballot}, 64'h30);
    ev_pred = 32'hABCD00F0;
    #1;
    check(ballot == 32'h000000F0 && vote_all, "R10", {31'b0, vote_all, ballot}, 64'h1_000000F0);

    // R8 overflow on a full stack
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(2'b01, 1'b0, 32'h1000 + i, 32'h0);
    check(!overflow, "R8", 64'(overflow), 64'h0);
    step(2'b01, 1'b0, 32'h2000, 32'h0);
    check(overflow, "R8", 64'(overflow), 64'h1);
    check(pc == START + DEPTH + 1, "R3", 64'(pc), 64'(START + DEPTH + 1));
    step(2'b10, 1'b0, 32'h3000, 32'h0000000F);
    check(overflow && !busy, "R8", {62'b0, overflow, busy}, 64'h2);
    check(pc == START + DEPTH + 1 && active_mask == '1, "R8", {pc, active_mask},
          {START + DEPTH + 1, 32'hFFFFFFFF});
    step(2'b00, 1'b0, 32'h0, 32'h0);
    check(!overflow, "R8", 64'(overflow), 64'h0);
    // R6 LIFO unwinding of the full stack
    for (int i = DEPTH - 1; i >= 0; i--) begin
      step(2'b11, 1'b1, 32'h0, 32'h0);
      check(pc == 32'h1000 + i && !underflow, "R6", 64'(pc), 64'(32'h1000 + i));
    end
    step(2'b00, 1'b1, 32'h0, 32'h0);
    check(underflow && pc == 32'h1000, "R9", {31'b0, underflow, pc}, {31'b0, 1'b1, 32'h1000});
    step(2'b00, 1'b0, 32'h0, 32'h0);
    check(!underflow && pc == 32'h1001, "R9", {31'b0, underflow, pc}, {32'b0, 32'h1001});

    // R1 reset in mid-split
    step(2'b01, 1'b0, 32'h700, 32'h0);
    step(2'b10, 1'b0, 32'h800, 32'h00000001);
    do_reset();
    @(negedge clk);
    check(active_mask == '1 && pc == START && !busy, "R1", {31'b0, busy, pc}, {32'b0, START});
    step(2'b00, 1'b1, 32'h0, 32'h0);
    check(underflow, "R1", 64'(underflow), 64'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule